// File: doc/BRIEF.md
# RV32I Integer ALU

A purely combinational 32-bit arithmetic and logic unit for the integer register-register and register-immediate operations of a 32-bit RISC-V core. It takes two operands, the 3-bit function code of the instruction, the alternate-operation bit (instruction bit 30), a flag that marks the immediate form, and a flag that requests the upper-immediate pass-through. It returns one 32-bit result in the same cycle.

The operand multiplexer in front of the unit supplies the second operand. For immediate forms, that operand is already the sign-extended immediate. For the upper-immediate load, it is the shifted immediate. The unit produces no flags, and arithmetic overflow is dropped. Because the block has no storage, it has no valid/ready handshake. The result follows the inputs combinationally, and any back-pressure is handled by the pipeline register that captures it.

Top module: `rv_int_alu`

## Requirements
- R1: With fn3 = 000 and no subtract request, the result is (op_a + op_b) mod 2^32, and overflow is discarded.
- R2: With fn3 = 000, alt = 1 and imm_form = 0, the result is (op_a - op_b) mod 2^32.
- R3: With fn3 = 000 and imm_form = 1, the result is an add whatever the value of alt.
- R4: With fn3 = 010, the result is 1 when op_a < op_b as signed two's-complement values, and 0 otherwise.
- R5: With fn3 = 011, the result is 1 when op_a < op_b as unsigned values, and 0 otherwise. A sign-extended immediate in op_b is compared as an unsigned value.
- R6: Every shift uses only op_b[4:0] as the shift amount, and op_b[31:5] has no effect on the result.
- R7: With fn3 = 001, the result is op_a shifted left, with zeros filling the low bits.
- R8: With fn3 = 101, alt = 0 gives a logical right shift that fills with zeros. alt = 1 gives an arithmetic right shift that fills with op_a[31]. Both forms behave this way.
- R9: fn3 = 100, 110 and 111 give the bitwise XOR, OR and AND of the operands, respectively.
- R10: When pass_b = 1, the result equals op_b, and fn3, alt and imm_form are ignored.
- R11: alt has no effect for any fn3 other than 000 and 101.
- R12: The no-operation encoding (add, both operands zero) yields a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand (rs1 value) |
| op_b | input | 32 | Second operand (rs2 value, extended immediate or upper immediate) |
| fn3 | input | 3 | Instruction function code |
| alt | input | 1 | Alternate-operation bit (instruction bit 30) |
| imm_form | input | 1 | Marks the register-immediate form |
| pass_b | input | 1 | Upper-immediate pass-through request |
| result | output | 32 | Operation result |

## Verification
Two functions can be requested at once in this block. The first case is a pass-through request that arrives together with any function code. The second case is the alternate bit arriving in immediate form, where it must select the arithmetic shift and must not select a subtract. The bench sweeps every combination of fn3, alt, imm_form and pass_b over a set of corner operands: signs, extremes, and shift amounts with dirty upper bits. For each combination it compares the output against an arithmetic model that follows the precedence stated in R10, R3 and R8.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLL  = 4'd2,
    OP_SLT  = 4'd3,
    OP_SLTU = 4'd4,
    OP_XOR  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SRA  = 4'd7,
    OP_OR   = 4'd8,
    OP_AND  = 4'd9,
    OP_PASS = 4'd10
  } alu_op_e;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [2:0] fn3,
  input  logic       alt,
  input  logic       imm_form,
  input  logic       pass_b,
  output alu_op_e    op
);
  always_comb begin
    if (pass_b) begin
      op = OP_PASS;
    end else begin
      unique case (fn3)
        3'b000:  op = (alt && !imm_form) ? OP_SUB : OP_ADD;
        3'b001:  op = OP_SLL;
        3'b010:  op = OP_SLT;
        3'b011:  op = OP_SLTU;
        3'b100:  op = OP_XOR;
        3'b101:  op = alt ? OP_SRA : OP_SRL;
        3'b110:  op = OP_OR;
        default: op = OP_AND;
      endcase
    end
  end

  always_comb begin
    if (!pass_b && imm_form && fn3 == 3'b000)
      a_r3_imm_never_sub: assert (op == OP_ADD);
    if (pass_b)
      a_r10_pass_wins: assert (op == OP_PASS);
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W:0] wide;
  logic       carry;

  always_comb begin
    wide  = {1'b0, a} + {1'b0, b ^ {W{sub}}} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    carry = wide[W];
    lt_u  = ~carry;
    lt_s  = (a[W-1] ^ b[W-1]) ? a[W-1] : sum[W-1];
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] shamt,
  input  logic           left,
  input  logic           arith,
  output logic [W-1:0]   res
);
  logic [W-1:0] a_rev;
  logic [W-1:0] src;
  logic [W:0]   ext;
  logic [W-1:0] shr;
  logic [W-1:0] shr_rev;
  logic         fill;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign a_rev[i]   = a[W-1-i];
    assign shr_rev[i] = shr[W-1-i];
  end

  always_comb begin
    src  = left ? a_rev : a;
    fill = arith & ~left & a[W-1];
    ext  = $signed({fill, src}) >>> shamt;
    shr  = ext[W-1:0];
    res  = left ? shr_rev : shr;
  end
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
  import alu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [2:0]      fn3,
  input  logic            alt,
  input  logic            imm_form,
  input  logic            pass_b,
  output logic [XLEN-1:0] result
);
  alu_op_e          op;
  logic [XLEN-1:0]  sum;
  logic [XLEN-1:0]  sh_res;
  logic             lt_s;
  logic             lt_u;
  logic             do_sub;

  alu_op_decode u_dec (
    .fn3      (fn3),
    .alt      (alt),
    .imm_form (imm_form),
    .pass_b   (pass_b),
    .op       (op)
  );

  assign do_sub = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);

  alu_addsub #(.W(XLEN)) u_add (
    .a    (op_a),
    .b    (op_b),
    .sub  (do_sub),
    .sum  (sum),
    .lt_s (lt_s),
    .lt_u (lt_u)
  );

  alu_shift #(.W(XLEN)) u_sh (
    .a     (op_a),
    .shamt (op_b[SHW-1:0]),
    .left  (op == OP_SLL),
    .arith (op == OP_SRA),
    .res   (sh_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:   result = sum;
      OP_SLT:           result = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU:          result = {{(XLEN-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL,
      OP_SRA:           result = sh_res;
      OP_XOR:           result = op_a ^ op_b;
      OP_OR:            result = op_a | op_b;
      OP_AND:           result = op_a & op_b;
      default:          result = op_b;
    endcase
  end

  always_comb begin
    if (op == OP_ADD)
      a_r1_add_inverse: assert (result - op_b == op_a);
    if (op == OP_SUB)
      a_r2_sub_inverse: assert (result + op_b == op_a);
    if (op == OP_SLT || op == OP_SLTU)
      a_r4_r5_bool_out: assert (result[XLEN-1:1] == '0);
    if (op == OP_SLTU)
      a_r5_unsigned_cmp: assert (result[0] == (op_a < op_b));
    if (op == OP_SLL && op_b[SHW-1:0] != '0)
      a_r7_low_zero: assert (result[0] == 1'b0);
    if (op == OP_SRA)
      a_r8_sign_fill: assert (result[XLEN-1] == op_a[XLEN-1]);
    if (op == OP_SRL && op_b[SHW-1:0] != '0)
      a_r8_zero_fill: assert (result[XLEN-1] == 1'b0);
    if (pass_b)
      a_r10_pass_out: assert (result == op_b);
  end
endmodule

// File: tb/rv_int_alu_test.sv
module rv_int_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a, op_b, result;
  logic [2:0]  fn3;
  logic        alt, imm_form, pass_b;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rv_int_alu uut (
    .op_a     (op_a),
    .op_b     (op_b),
    .fn3      (fn3),
    .alt      (alt),
    .imm_form (imm_form),
    .pass_b   (pass_b),
    .result   (result)
  );

  function automatic logic [31:0] pick(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h0000_0025;
      6: return 32'hFFFF_FFE3;
      7: return 32'h1234_5678;
      8: return 32'hF0F0_0F1F;
      9: return 32'h0000_0020;
      default: return 32'hA5A5_5A5A;
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [2:0] f, input logic al,
                                        input logic im, input logic pb);
    logic [4:0] sh;
    sh = b[4:0];
    if (pb) return b;
    case (f)
      3'b000: return (al && !im) ? a - b : a + b;
      3'b001: return a << sh;
      3'b010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'b011: return (a < b) ? 32'd1 : 32'd0;
      3'b100: return a ^ b;
      3'b101: return al ? 32'($signed(a) >>> sh) : a >> sh;
      3'b110: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] f, input logic al,
                                input logic im, input logic pb);
    if (pb) return "R10";
    case (f)
      3'b000: return im ? "R3" : (al ? "R2" : "R1");
      3'b001: return "R7/R6";
      3'b010: return al ? "R4/R11" : "R4";
      3'b011: return al ? "R5/R11" : "R5";
      3'b101: return "R8/R6";
      default: return al ? "R9/R11" : "R9";
    endcase
  endfunction

  task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h fn3=%b alt=%b imm=%b pass=%b)",
               t, got, exp, op_a, op_b, fn3, alt, imm_form, pass_b);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] f,
                       input logic al, input logic im, input logic pb);
    @(negedge clk);
    op_a = a; op_b = b; fn3 = f; alt = al; imm_form = im; pass_b = pb;
    #2;
  endtask

  initial begin
    op_a = '0; op_b = '0; fn3 = '0; alt = 1'b0; imm_form = 1'b0; pass_b = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #2;
    // R12: state after reset with the no-operation encoding
    check("R12", result, 32'h0);
    apply(32'h0, 32'h0, 3'b000, 1'b0, 1'b1, 1'b0);
    check("R12", result, 32'h0);

    // R1: wrap on overflow
    apply(32'hFFFF_FFFF, 32'h2, 3'b000, 1'b0, 1'b0, 1'b0);
    check("R1", result, 32'h1);
    // R2: subtract wraps below zero
    apply(32'h0, 32'h1, 3'b000, 1'b1, 1'b0, 1'b0);
    check("R2", result, 32'hFFFF_FFFF);
    // R3: immediate form with alt set still adds
    apply(32'h10, 32'hFFFF_FFFF, 3'b000, 1'b1, 1'b1, 1'b0);
    check("R3", result, 32'hF);
    // R5: sign-extended immediate -1 seen as max unsigned
    apply(32'h5, 32'hFFFF_FFFF, 3'b011, 1'b0, 1'b1, 1'b0);
    check("R5", result, 32'h1);
    // R4: -1 < 5 signed
    apply(32'hFFFF_FFFF, 32'h5, 3'b010, 1'b0, 1'b0, 1'b0);
    check("R4", result, 32'h1);
    // R6: amount 32 has low bits 0, no shift
    apply(32'h8000_0001, 32'h20, 3'b101, 1'b1, 1'b0, 1'b0);
    check("R6", result, 32'h8000_0001);
    // R8: arithmetic shift by 4 in immediate form
    apply(32'h8000_0000, 32'h4, 3'b101, 1'b1, 1'b1, 1'b0);
    check("R8", result, 32'hF800_0000);
    // R10: pass-through overrides a subtract request
    apply(32'h1, 32'hABCD_E000, 3'b000, 1'b1, 1'b0, 1'b1);
    check("R10", result, 32'hABCD_E000);

    // Sweep of every control combination over corner operands
    for (int i = 0; i < 11; i++)
      for (int j = 0; j < 11; j++)
        for (int c = 0; c < 64; c++) begin
          logic [2:0] f;
          logic al, im, pb;
          f  = 3'(c & 7);
          al = c[3];
          im = c[4];
          pb = c[5];
          apply(pick(i), pick(j), f, al, im, pb);
          check(tag(f, al, im, pb), result, model(pick(i), pick(j), f, al, im, pb));
        end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule